// File: doc/BRIEF.md
# Lock-Step Parallel Vector Sum Unit

The block adds up the eight signed elements of a vector using a row of identical processing lanes that all obey one shared sequencer. Each lane holds one element. On every step the sequencer names a stride, and every selected lane adds in the value held by the lane that lies that stride above it. The number of live partial sums halves on each step, so lane 0 holds the total after three steps.

A mode bit, captured when the run starts, picks the stride order. Neighbour-first order uses strides 1, 2 and 4. Far-first order uses strides 4, 2 and 1. A user loads the vector in one cycle while the block is idle, pulses start, and reads the result when the one-cycle done flag is high. Lanes that are not selected in a step keep their contents. A later start with no new load therefore reduces whatever the lanes hold at that moment.

Top module: `simd_red_top`

## Requirements
- R1: After reset, done_o is low, every lane holds zero and the sequencer is idle. A start that is given without a load therefore yields a sum of 0.
- R2: A load_i pulse in the idle state writes word k of vec_i (bits 16k+15 down to 16k) into lane k, sign-extended to 19 bits.
- R3: With mode_i = 0 at start, the steps use strides 1, 2 and 4. In each step, lane i adds lane i+stride when i is a multiple of twice the stride.
- R4: With mode_i = 1 at start, the steps use strides 4, 2 and 1. In each step, lane i adds lane i+stride when i is below the stride.
- R5: Lanes that are not selected in a step keep their value. A second start with no load in between reduces the contents left by the previous run.
- R6: If start_i is sampled high while idle at clock edge k, one step is applied at each of edges k+1, k+2 and k+3. done_o is then high for exactly one cycle, after edge k+3, and sum_o carries lane 0 in that cycle.
- R7: start_i is ignored while a reduction is running and during the done cycle. It produces no extra done pulse.
- R8: load_i is ignored outside the idle state, including during the done cycle.
- R9: The stride order is fixed by mode_i at the accepted start. Later changes to mode_i have no effect on that run.
- R10: The 19-bit result never overflows for any freshly loaded vector, and both modes give the same total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Parallel load of all lanes (idle only) |
| vec_i | input | 128 | Eight 16-bit signed words, word k in bits 16k+15:16k |
| start_i | input | 1 | Start strobe (idle only) |
| mode_i | input | 1 | 0 neighbour-first, 1 far-first |
| done_o | output | 1 | One-cycle flag: sum_o valid |
| sum_o | output | 19 | Lane 0 contents, signed |

## Verification
Any wrong lane selection, wrong stride or dropped step shows up as a wrong sum_o in the done cycle, four cycles after the start, because every lane's contents feed lane 0 by the third step. A lane that is disturbed when it should hold stays hidden after the first run. It shows up on the next rerun without a load, which the bench checks against its own model of all eight lanes. A sequencer that accepts starts or loads it should ignore shows up as an extra done pulse, a changed sum_o in or after the done cycle, or a result that differs from the model.

// File: rtl/simd_red_pkg.sv
package simd_red_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/simd_red_seq.sv
module simd_red_seq
  import simd_red_pkg::*;
#(
  parameter  int STEPS = 3,
  localparam int CW    = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             mode_i,
  output seq_state_e       state_o,
  output logic [CW-1:0]    step_o,
  output logic             far_o,
  output logic             run_o,
  output logic             done_o
);
  seq_state_e    state_q;
  logic [CW-1:0] step_q;
  logic          far_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      far_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RUN;
          step_q  <= '0;
          far_q   <= mode_i;
        end
        ST_RUN: begin
          if (step_q == CW'(STEPS-1)) state_q <= ST_DONE;
          else                        step_q  <= step_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign step_o  = step_q;
  assign far_o   = far_q;
  assign run_o   = (state_q == ST_RUN);
  assign done_o  = (state_q == ST_DONE);
endmodule

// File: rtl/simd_red_mask.sv
module simd_red_mask #(
  parameter  int LANES = 8,
  parameter  int STEPS = 3,
  localparam int CW    = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic             run_i,
  input  logic             far_i,
  input  logic [CW-1:0]    step_i,
  output logic [STEPS-1:0] stride_oh_o,
  output logic [LANES-1:0] add_en_o
);
  logic [CW-1:0] slog;

  always_comb begin
    // far-first walks the stride exponents downward
    slog        = far_i ? (CW'(STEPS-1) - step_i) : step_i;
    stride_oh_o = '0;
    add_en_o    = '0;
    if (run_i) begin
      stride_oh_o[slog] = 1'b1;
      for (int i = 0; i < LANES; i++) begin
        if (far_i ? (i < (1 << slog)) : ((i % (2 << slog)) == 0))
          add_en_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/simd_red_route.sv
module simd_red_route #(
  parameter int LANES = 8,
  parameter int STEPS = 3,
  parameter int W_ACC = 19
) (
  input  logic [LANES-1:0][W_ACC-1:0] lane_i,
  input  logic [STEPS-1:0]            stride_oh_i,
  output logic [LANES-1:0][W_ACC-1:0] partner_o
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [STEPS-1:0][W_ACC-1:0] cand;
    for (genvar s = 0; s < STEPS; s++) begin : g_str
      if (i + (1 << s) < LANES) begin : g_ok
        assign cand[s] = lane_i[i + (1 << s)];
      end else begin : g_none
        assign cand[s] = '0;
      end
    end
    always_comb begin
      partner_o[i] = '0;
      for (int s = 0; s < STEPS; s++)
        if (stride_oh_i[s]) partner_o[i] = cand[s];
    end
  end
endmodule

// File: rtl/simd_red_lane.sv
module simd_red_lane #(
  parameter  int W_IN  = 16,
  parameter  int W_ACC = 19,
  localparam int W_EXT = W_ACC - W_IN
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [W_IN-1:0]  din_i,
  input  logic             add_i,
  input  logic [W_ACC-1:0] partner_i,
  output logic [W_ACC-1:0] acc_o
);
  logic [W_ACC-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (load_i) acc_q <= {{W_EXT{din_i[W_IN-1]}}, din_i};
    else if (add_i)  acc_q <= acc_q + partner_i;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/simd_red_top.sv
module simd_red_top
  import simd_red_pkg::*;
#(
  parameter  int LANES = 8,
  parameter  int W_IN  = 16,
  localparam int STEPS = $clog2(LANES),
  localparam int W_ACC = W_IN + STEPS,
  localparam int CW    = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic [LANES*W_IN-1:0] vec_i,
  input  logic                  start_i,
  input  logic                  mode_i,
  output logic                  done_o,
  output logic [W_ACC-1:0]      sum_o
);
  seq_state_e                  state_q;
  logic [CW-1:0]               step_q;
  logic                        far_q;
  logic                        run;
  logic                        load_en;
  logic [STEPS-1:0]            stride_oh;
  logic [LANES-1:0]            add_en;
  logic [LANES-1:0][W_ACC-1:0] lane_q;
  logic [LANES-1:0][W_ACC-1:0] partner;

  simd_red_seq #(.STEPS(STEPS)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .mode_i  (mode_i),
    .state_o (state_q),
    .step_o  (step_q),
    .far_o   (far_q),
    .run_o   (run),
    .done_o  (done_o)
  );

  simd_red_mask #(.LANES(LANES), .STEPS(STEPS)) u_mask (
    .run_i       (run),
    .far_i       (far_q),
    .step_i      (step_q),
    .stride_oh_o (stride_oh),
    .add_en_o    (add_en)
  );

  simd_red_route #(.LANES(LANES), .STEPS(STEPS), .W_ACC(W_ACC)) u_route (
    .lane_i      (lane_q),
    .stride_oh_i (stride_oh),
    .partner_o   (partner)
  );

  assign load_en = load_i && (state_q == ST_IDLE);

  for (genvar k = 0; k < LANES; k++) begin : g_pe
    simd_red_lane #(.W_IN(W_IN), .W_ACC(W_ACC)) u_lane (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (load_en),
      .din_i     (vec_i[k*W_IN +: W_IN]),
      .add_i     (add_en[k]),
      .partner_i (partner[k]),
      .acc_o     (lane_q[k])
    );
  end

  assign sum_o = lane_q[0];
endmodule

// File: rtl/simd_red_chk.sv
module simd_red_chk
  import simd_red_pkg::*;
#(
  parameter  int LANES = 8,
  parameter  int STEPS = 3,
  parameter  int W_ACC = 19,
  localparam int CW    = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             load_i,
  input logic             done_o,
  input logic [W_ACC-1:0] sum_o,
  input seq_state_e       state_q,
  input logic [CW-1:0]    step_q,
  input logic             far_q,
  input logic [STEPS-1:0] stride_oh,
  input logic [LANES-1:0] add_en
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_DONE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(start_i && state_q == ST_IDLE, STEPS + 1)); // R6
  AST_STRIDE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(stride_oh)); // R3
  AST_FAR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_RUN && step_q != '0) || state_q == ST_DONE) |-> $stable(far_q)); // R9
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && state_q != ST_IDLE) |=> !(state_q == ST_RUN && step_q == '0)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !load_i) |=> $stable(sum_o)); // R5
  AST_NO_ADD_OUTSIDE_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_RUN) |-> (add_en == '0)); // R5
  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE) |=> $stable(sum_o)); // R8
endmodule

bind simd_red_top simd_red_chk #(.LANES(LANES), .STEPS(STEPS), .W_ACC(W_ACC)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .load_i    (load_i),
  .done_o    (done_o),
  .sum_o     (sum_o),
  .state_q   (state_q),
  .step_q    (step_q),
  .far_q     (far_q),
  .stride_oh (stride_oh),
  .add_en    (add_en)
);

// File: tb/simd_red_top_tb.sv
module simd_red_top_tb;
  localparam int LANES = 8;
  localparam int W_IN  = 16;
  localparam int W_ACC = 19;

  logic                  clk_i = 1'b0;
  logic                  rst_ni = 1'b0;
  logic                  load_i = 1'b0;
  logic [LANES*W_IN-1:0] vec_i = '0;
  logic                  start_i = 1'b0;
  logic                  mode_i = 1'b0;
  logic                  done_o;
  logic [W_ACC-1:0]      sum_o;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  logic [W_ACC-1:0] mdl [LANES];
  logic [W_ACC-1:0] exp_q [$];
  string            tag_q [$];
  logic [W_ACC-1:0] last_sum;

  always #10 clk_i = ~clk_i;

  simd_red_top u_dut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .vec_i   (vec_i),
    .start_i (start_i),
    .mode_i  (mode_i),
    .done_o  (done_o),
    .sum_o   (sum_o)
  );

  task automatic chk(input logic [W_ACC-1:0] act, input logic [W_ACC-1:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d", tag, $signed(act), $signed(exp));
    end
  endtask

  // monitor: pops the scoreboard on each done pulse
  always @(negedge clk_i) begin
    if (rst_ni && done_o && !finished) begin
      last_sum = sum_o;
      if (exp_q.size() == 0) begin
        chk(1, 0, "R7 unexpected done");
      end else begin
        chk(sum_o, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic model_load(input logic [LANES*W_IN-1:0] v);
    for (int k = 0; k < LANES; k++)
      mdl[k] = {{(W_ACC-W_IN){v[k*W_IN+W_IN-1]}}, v[k*W_IN +: W_IN]};
  endtask

  function automatic logic [W_ACC-1:0] model_reduce(input bit far);
    logic [W_ACC-1:0] old [LANES];
    for (int s = 0; s < 3; s++) begin
      int st;
      st = far ? (1 << (2 - s)) : (1 << s);
      old = mdl;
      for (int i = 0; i < LANES; i++)
        if (far ? (i < st) : ((i % (2*st)) == 0)) mdl[i] = old[i] + old[i+st];
    end
    return mdl[0];
  endfunction

  task automatic do_load(input logic [LANES*W_IN-1:0] v);
    vec_i = v; load_i = 1'b1;
    @(negedge clk_i);
    load_i = 1'b0;
    model_load(v);
  endtask

  // driver: start, push expectation, check timing; optionally disturb
  task automatic do_run(input bit far, input bit disturb, input string tag);
    logic [W_ACC-1:0] e;
    e = model_reduce(far);
    exp_q.push_back(e); tag_q.push_back(tag);
    mode_i = far; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int c = 0; c < 3; c++) begin
      chk(done_o, 0, "R6 early done");
      if (disturb) begin
        start_i = 1'b1; load_i = 1'b1; mode_i = ~far;
        vec_i = {$urandom, $urandom, $urandom, $urandom};
      end
      @(negedge clk_i);
      start_i = 1'b0; load_i = 1'b0;
    end
    chk(done_o, 1, "R6 done missing");
    if (disturb) begin
      start_i = 1'b1; load_i = 1'b1;
      vec_i = {$urandom, $urandom, $urandom, $urandom};
    end
    @(negedge clk_i);
    start_i = 1'b0; load_i = 1'b0;
    chk(done_o, 0, "R6 done width");
    chk(sum_o, e, "R8 sum after done");
    if (disturb) begin
      for (int c = 0; c < 5; c++) begin
        chk(done_o, 0, "R7 start in done cycle");
        @(negedge clk_i);
      end
    end
  endtask

  function automatic logic [LANES*W_IN-1:0] fill(input int val);
    logic [LANES*W_IN-1:0] v;
    for (int k = 0; k < LANES; k++) v[k*W_IN +: W_IN] = W_IN'(val);
    return v;
  endfunction

  initial begin
    logic [LANES*W_IN-1:0] v;
    logic [W_ACC-1:0] r_n;
    int ref_sum;
    for (int k = 0; k < LANES; k++) mdl[k] = '0;
    repeat (3) @(negedge clk_i);
    chk(done_o, 0, "R1 reset done");
    chk(sum_o, 0, "R1 reset sum");
    rst_ni = 1'b1;
    @(negedge clk_i);
    do_run(0, 0, "R1 start without load");

    for (int k = 0; k < LANES; k++) v[k*W_IN +: W_IN] = W_IN'(k + 1);
    do_load(v);
    do_run(0, 0, "R3 neighbour 1..8");
    do_load(v);
    do_run(1, 0, "R4 far 1..8");
    chk(last_sum, 36, "R2 lane order sum");

    do_load(fill(-32768));
    do_run(1, 0, "R10 all min far");
    chk(last_sum, 19'h40000, "R10 min no overflow");
    do_load(fill(32767));
    do_run(0, 0, "R10 all max neighbour");
    chk(last_sum, 19'd262136, "R10 max no overflow");

    for (int k = 0; k < LANES; k++) v[k*W_IN +: W_IN] = W_IN'(-(k * 1000) + 3);
    do_load(v);
    do_run(0, 0, "R3 neighbour signed");
    do_run(0, 0, "R5 rerun neighbour retained lanes");
    do_run(1, 0, "R5 rerun far retained lanes");

    v = {$urandom, $urandom, $urandom, $urandom};
    do_load(v);
    do_run(1, 1, "R9 far with mode toggles and ignored start/load");
    do_load(v);
    do_run(0, 1, "R8 neighbour with ignored load");

    for (int t = 0; t < 40; t++) begin
      v = {$urandom, $urandom, $urandom, $urandom};
      ref_sum = 0;
      for (int k = 0; k < LANES; k++) ref_sum += int'($signed(v[k*W_IN +: W_IN]));
      do_load(v);
      do_run(0, 0, "R3 random neighbour");
      r_n = last_sum;
      chk(r_n, W_ACC'(ref_sum), "R10 neighbour vs software sum");
      do_load(v);
      do_run(1, 0, "R4 random far");
      chk(last_sum, r_n, "R10 modes agree");
    end
    chk(W_ACC'(exp_q.size()), 0, "R6 missing done pulses");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog act=0 exp=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule